// File: doc/BRIEF.md
# Dual-Mode Proximity-Card Frame Serializer

This block turns a byte string held in a local buffer into the serial bit stream of one proximity-card (ISO 14443 Type B) frame. It adds a training run of ones, a start-of-frame marker, per-byte character framing and an end-of-frame marker. It does not compute a CRC. Bytes leave exactly as written, so any check bytes must already be in the buffer. A mode pin picks one of two framings. Card-side (tag) framing repeats every logical bit as four identical samples. Reader-side framing sends one sample per bit and uses its own guard bits and padding.

Software or an upstream engine fills the buffer through a plain write port while the block is idle, sets the length and mode, and pulses `start`. Samples then leave on a valid/ready port. A sample is consumed only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low the current sample and `out_valid` hold steady, so a slow modulator can stall the frame for any number of cycles without losing or repeating samples. `done` reports the end of the frame.

Top module: `card_frame_ser`

## Requirements
- R1: After reset `out_valid`, `busy` and `done` are low.
- R2: With `mode_in` = 0 (tag framing), every logical bit appears as 4 consecutive equal samples, and a frame of N bytes is 4*(52+10N) samples long.
- R3: Tag framing as logical bits: 20 ones, then 10 zeros and 2 ones, then for each byte a zero, its 8 data bits least significant first and a one, then 10 zeros and 10 ones.
- R4: With `mode_in` = 1 (reader framing), one sample per bit: 40 ones, then 10 zeros, then for each byte two ones, a zero and its 8 data bits least significant first, then a single one, 10 zeros and 32 ones. A frame of N bytes is 93+11N samples long.
- R5: A length of 0 produces only the lead-in, start marker and end marker. A length above 64 is treated as 64.
- R6: The stream advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` keep their values into the next cycle.
- R7: `start` is accepted only while `busy` is low, and `out_valid` is high in the cycle after it is accepted. `mode_in` and `len_in` are captured when `start` is accepted. A `start` pulse, a mode change or a length change during a frame has no effect on that frame.
- R8: A write while idle stores `wr_data` at byte index `wr_addr`, and byte index i is sent as the i-th byte of the frame. Writes while `busy` is high are ignored.
- R9: `done` rises in the cycle after the last sample is accepted, with `out_valid` low. It stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 6 | Buffer byte index |
| wr_data | input | 8 | Byte to store |
| mode_in | input | 1 | Framing select: 0 tag, 1 reader |
| len_in | input | 7 | Number of bytes to send (clamped to 64) |
| start | input | 1 | Begin a frame (pulse) |
| out_valid | output | 1 | Sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_bit | output | 1 | Current sample (one when idle) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame finished |

## Verification
The bench builds the block with its default parameters: a 64-byte buffer and a tag oversampling factor of 4. These values bring the full-buffer frame, the clamp of an oversized length and the empty frame within reach in both framings. A reference model computes every expected sample from the segment lengths. The bench compares every accepted sample against it across a sweep of lengths and data patterns, with and without pseudo-random back-pressure. One frame also carries a mid-frame `start` pulse, a mode change, a length change and a buffer write, to show that none of them alters the samples that follow.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [2:0] {
    SEG_PRE, SEG_SOF_LO, SEG_SOF_HI, SEG_BYTE, SEG_EOF_LEAD, SEG_EOF_LO, SEG_EOF_HI
  } seg_e;

  typedef enum logic {MODE_TAG = 1'b0, MODE_RDR = 1'b1} mode_e;

  localparam int SEG_CNT_W       = 6;
  localparam int TAG_PRE_BITS    = 20;
  localparam int RDR_PRE_BITS    = 40;
  localparam int SOF_LO_BITS     = 10;
  localparam int TAG_SOF_HI_BITS = 2;
  localparam int EOF_LO_BITS     = 10;
  localparam int TAG_EOF_HI_BITS = 10;
  localparam int RDR_EOF_HI_BITS = 32;
  localparam int TAG_SLOTS       = 10;
  localparam int RDR_SLOTS       = 11;
endpackage

// File: rtl/cfs_byte_buf.sv
module cfs_byte_buf #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cfs_sample_rep.sv
module cfs_sample_rep
  import cfs_pkg::*;
#(
  parameter int OSF = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  beat,
  input  mode_e mode,
  output logic  bit_step
);
  logic at_end;

  generate
    if (OSF > 1) begin : g_rep
      localparam int SW = $clog2(OSF);
      logic [SW-1:0] sc_q;
      assign at_end = (mode == MODE_RDR) || (sc_q == SW'(OSF - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sc_q <= '0;
        else if (load) sc_q <= '0;
        else if (beat) sc_q <= at_end ? '0 : sc_q + 1'b1;
      end
    end else begin : g_norep
      assign at_end = 1'b1;
    end
  endgenerate

  assign bit_step = beat && at_end;
endmodule

// File: rtl/cfs_bit_seq.sv
module cfs_bit_seq
  import cfs_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  mode_e         mode,
  input  logic [LW-1:0] nbytes,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          bit_o,
  output logic          last_o
);
  seg_e                 seg_q, seg_n, after_sof, after_byte;
  logic [SEG_CNT_W-1:0] cnt_q, seg_len;
  logic [3:0]           slot_q, slot_max, di;
  logic [AW-1:0]        idx_q;
  logic                 tag, idx_last, cnt_end;

  assign tag      = (mode == MODE_TAG);
  assign slot_max = tag ? 4'(TAG_SLOTS - 1) : 4'(RDR_SLOTS - 1);
  assign idx_last = (LW'({1'b0, idx_q}) + LW'(1)) >= nbytes;

  always_comb begin
    case (seg_q)
      SEG_PRE:      seg_len = tag ? SEG_CNT_W'(TAG_PRE_BITS) : SEG_CNT_W'(RDR_PRE_BITS);
      SEG_SOF_LO:   seg_len = SEG_CNT_W'(SOF_LO_BITS);
      SEG_SOF_HI:   seg_len = SEG_CNT_W'(TAG_SOF_HI_BITS);
      SEG_EOF_LO:   seg_len = SEG_CNT_W'(EOF_LO_BITS);
      SEG_EOF_HI:   seg_len = tag ? SEG_CNT_W'(TAG_EOF_HI_BITS) : SEG_CNT_W'(RDR_EOF_HI_BITS);
      default:      seg_len = SEG_CNT_W'(1);
    endcase
  end
  assign cnt_end = (cnt_q == seg_len - 1'b1);

  assign after_byte = tag ? SEG_EOF_LO : SEG_EOF_LEAD;
  assign after_sof  = (nbytes != '0) ? SEG_BYTE : after_byte;

  always_comb begin
    case (seg_q)
      SEG_PRE:      seg_n = SEG_SOF_LO;
      SEG_SOF_LO:   seg_n = tag ? SEG_SOF_HI : after_sof;
      SEG_SOF_HI:   seg_n = after_sof;
      SEG_BYTE:     seg_n = after_byte;
      SEG_EOF_LEAD: seg_n = SEG_EOF_LO;
      SEG_EOF_LO:   seg_n = SEG_EOF_HI;
      default:      seg_n = seg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_PRE; cnt_q <= '0; slot_q <= '0; idx_q <= '0;
    end else if (load) begin
      seg_q <= SEG_PRE; cnt_q <= '0; slot_q <= '0; idx_q <= '0;
    end else if (step) begin
      if (seg_q == SEG_BYTE) begin
        if (slot_q == slot_max) begin
          slot_q <= '0;
          if (idx_last) seg_q <= seg_n;
          else          idx_q <= idx_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else if (cnt_end) begin
        cnt_q <= '0;
        seg_q <= seg_n;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign di = tag ? (slot_q - 4'd1) : (slot_q - 4'd3);

  always_comb begin
    case (seg_q)
      SEG_SOF_LO, SEG_EOF_LO: bit_o = 1'b0;
      SEG_BYTE: begin
        if (tag)               bit_o = (slot_q == 4'd0) ? 1'b0 :
                                       (slot_q == slot_max) ? 1'b1 : rd_data[di[2:0]];
        else if (slot_q < 4'd2) bit_o = 1'b1;
        else if (slot_q == 4'd2) bit_o = 1'b0;
        else                   bit_o = rd_data[di[2:0]];
      end
      default: bit_o = 1'b1;
    endcase
  end

  assign last_o  = (seg_q == SEG_EOF_HI) && cnt_end;
  assign rd_addr = idx_q;
endmodule

// File: rtl/card_frame_ser.sv
module card_frame_ser
  import cfs_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int TAG_OSF = 4,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          mode_in,
  input  logic [LW-1:0] len_in,
  input  logic          start,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          busy,
  output logic          done
);
  logic          busy_q, done_q, start_acc, beat, step, last, seq_bit;
  mode_e         mode_q;
  logic [LW-1:0] nbytes_q, len_clamp;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  assign start_acc = start && !busy_q;
  assign beat      = busy_q && out_ready;
  assign len_clamp = (len_in > LW'(MAX_LEN)) ? LW'(MAX_LEN) : len_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; mode_q <= MODE_TAG; nbytes_q <= '0;
    end else if (start_acc) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      mode_q   <= mode_e'(mode_in);
      nbytes_q <= len_clamp;
    end else if (step && last) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  cfs_byte_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk(clk), .wr_en(wr_en && !busy_q), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfs_sample_rep #(.OSF(TAG_OSF)) u_rep (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .beat(beat), .mode(mode_q),
    .bit_step(step)
  );

  cfs_bit_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .step(step), .mode(mode_q),
    .nbytes(nbytes_q), .rd_data(rd_data), .rd_addr(rd_addr), .bit_o(seq_bit),
    .last_o(last)
  );

  assign out_valid = busy_q;
  assign out_bit   = busy_q ? seq_bit : 1'b1;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
  parameter int TAG_OSF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic busy,
  input logic done,
  input logic mode_q
);
  logic [7:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ph_q <= '0;
    else if (start && !busy)        ph_q <= '0;
    else if (out_valid && out_ready) ph_q <= (ph_q == 8'(TAG_OSF - 1)) ? '0 : ph_q + 1'b1;
  end

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bit));

  p_tag_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !mode_q && (ph_q != 8'(TAG_OSF - 1)) |=> out_bit == $past(out_bit));

  p_start_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> out_valid);

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(mode_q));

  // R3 and R4: both framings open with a one
  p_lead_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_bit);

  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  p_done_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready));
endmodule

bind card_frame_ser cfs_checker #(.TAG_OSF(TAG_OSF)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_ready(out_ready), .out_bit(out_bit), .busy(busy), .done(done),
  .mode_q(mode_q)
);

// File: tb/card_frame_ser_tb.sv
module card_frame_ser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       mode_in = 1'b0;
  logic [6:0] len_in = '0;
  logic       start = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_bit, busy, done;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  ref_mem [MAXL];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_frame_ser u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_in(mode_in), .len_in(len_in), .start(start), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_logical(input bit mode, input int nb, input int k0);
    int k = k0;
    if (!mode) begin
      if (k < 20) return 1'b1; k -= 20;
      if (k < 10) return 1'b0; k -= 10;
      if (k < 2)  return 1'b1; k -= 2;
      if (k < 10*nb) begin
        int b = k / 10; int s = k % 10;
        if (s == 0) return 1'b0;
        if (s == 9) return 1'b1;
        return ref_mem[b][s-1];
      end
      k -= 10*nb;
      if (k < 10) return 1'b0;
      return 1'b1;
    end else begin
      if (k < 40) return 1'b1; k -= 40;
      if (k < 10) return 1'b0; k -= 10;
      if (k < 11*nb) begin
        int b = k / 11; int s = k % 11;
        if (s < 2)  return 1'b1;
        if (s == 2) return 1'b0;
        return ref_mem[b][s-3];
      end
      k -= 11*nb;
      if (k == 0) return 1'b1; k -= 1;
      if (k < 10) return 1'b0;
      return 1'b1;
    end
  endfunction

  task automatic load_mem(input int seed);
    for (int i = 0; i < MAXL; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'(i);
      wr_data = 8'((i * 37 + seed * 11) ^ (seed << (i % 3)));
      ref_mem[i] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input bit mode, input int len, input bit stall,
                           input bit poke, input string req);
    int nb = (len > MAXL) ? MAXL : len;
    int total = mode ? (93 + 11*nb) : 4*(52 + 10*nb);
    int s = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic prev_b = 1'b0;
    @(negedge clk);
    check(done == (checks > 3), "R9 done before start", done, checks > 3);
    mode_in = mode; len_in = 7'(len); start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(out_valid == 1'b1, "R7 valid after start", out_valid, 1);
    check(done == 1'b0, "R9 done cleared by start", done, 0);
    forever begin
      logic v, b, r;
      if (cyc != 0) @(negedge clk);
      cyc++;
      start = 1'b0; wr_en = 1'b0;
      v = out_valid; b = out_bit;
      if (!v) break;
      if (cyc > 20000) begin
        check(1'b0, "R9 watchdog", s, total);
        break;
      end
      if (prev_stall) check(b == prev_b, "R6 hold under stall", b, prev_b);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
      out_ready = r;
      if (poke && s == 45) begin
        start = 1'b1; mode_in = ~mode; len_in = 7'd3;
        wr_en = 1'b1; wr_addr = 6'd0; wr_data = ~ref_mem[0];
      end
      if (r) begin
        logic e = exp_logical(mode, nb, mode ? s : s / 4);
        check(b == e, $sformatf("%s sample %0d", req, s), b, e);
        s++;
      end
      prev_stall = !r; prev_b = b;
    end
    out_ready = 1'b0;
    check(s == total, mode ? "R4 frame length" : "R2 frame length", s, total);
    check(done == 1'b1, "R9 done after frame", done, 1);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && out_valid == 1'b0, "R9 done holds while idle", done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL R9 global watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rst_n = 1'b1;
    load_mem(1);
    // R5 empty frames, then R3/R4 with data, R8 data follows written bytes
    run_frame(1'b0, 0, 1'b0, 1'b0, "R5");
    run_frame(1'b1, 0, 1'b0, 1'b0, "R5");
    foreach (ref_mem[i]) begin end
    for (int ln = 1; ln <= 5; ln++) begin
      run_frame(1'b0, ln, 1'b0, 1'b0, "R3");
      run_frame(1'b1, ln, 1'b0, 1'b0, "R4");
    end
    load_mem(7);
    run_frame(1'b0, 64, 1'b0, 1'b0, "R8");
    run_frame(1'b1, 64, 1'b0, 1'b0, "R8");
    run_frame(1'b1, 100, 1'b0, 1'b0, "R5");
    run_frame(1'b0, 127, 1'b0, 1'b0, "R5");
    // R6 pseudo-random back-pressure
    run_frame(1'b0, 3, 1'b1, 1'b0, "R6");
    run_frame(1'b1, 9, 1'b1, 1'b0, "R6");
    // R7/R8 start, mode, length and write during a frame are ignored
    run_frame(1'b0, 4, 1'b0, 1'b1, "R7");
    run_frame(1'b1, 6, 1'b1, 1'b1, "R8");
    run_frame(1'b0, 2, 1'b0, 1'b0, "R8");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule